// File: doc/BRIEF.md
# Snooping MESI Coherence Controller for a Direct-Mapped Cache

This block keeps one small direct-mapped cache coherent with its peers on a shared snooping bus. Each line holds a tag, one data word and one of four coherence states: Invalid (no data), Shared (clean, other copies may exist), Exclusive (clean, only copy) and Modified (dirty, only copy). The local processor side is a simple request/done handshake. Misses, upgrades and dirty evictions become bus transactions. The bus has four commands: read, read-for-ownership, invalidate and write-back.

Every cache watches all bus traffic that it did not issue itself. It answers in the same cycle with a wired-OR "line present" flag, a data-supply flag with the data word, and a flush flag that tells memory to absorb a dirty word. Invalidate acknowledgments come back one cycle after the invalidate. A fixed-priority arbiter, also provided here, gives the bus to one cache at a time. A cache keeps the bus from its first command until its request completes, so an eviction write-back and the fill after it form one transaction.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req` and `cpu_done` are low and no bus command is driven, so the first access to any address goes to the bus.
- R2: A local read miss issues a read (command code 1). When no peer reports the line present, the data comes from memory and the line is installed Exclusive.
- R3: A local read hit returns the stored word with no bus command.
- R4: A snooped read that hits an Exclusive line is answered by this cache with its own data and no memory write. Both copies end Shared, so a later write by either cache issues an invalidate.
- R5: A snooped read that hits a Modified line raises the flush flag, which writes the dirty word to memory, and also supplies the word. Both copies end Shared.
- R6: A local write to a Shared line issues an invalidate (command code 3). Completion waits for `inv_ack_all_i`, however late it comes, and the line then becomes Modified. A peer Shared copy becomes Invalid.
- R7: A local write hit on an Exclusive or Modified line completes with no bus command and leaves the line Modified.
- R8: A local write miss issues a read-for-ownership (command code 2) and installs the line Modified. A peer holding it Modified supplies its word without a memory write. Every peer copy becomes Invalid.
- R9: The address splits into index (low bits) and tag (high bits). A miss that displaces a Modified line first issues a write-back (command code 4) of the old address and word, then the fill. Displacing a clean line issues no write-back.
- R10: The arbiter grants at most one requester, favours the lowest index, and keeps a grant while its holder requests. A cache drives commands only while granted.
- R11: Every read, from either cache, returns the value of the latest completed write to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request pending, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | Request completes on this cycle's edge |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd_o | output | 3 | Issued command (0 none, 1 read, 2 read-for-ownership, 3 invalidate, 4 write-back) |
| bus_addr_o | output | ADDR_W | Issued address, zero when idle |
| bus_wdata_o | output | DATA_W | Write-back word, zero when idle |
| bus_fill_i | input | DATA_W | Fill word: peer-supplied if any, else memory |
| bus_shared_i | input | 1 | OR of peers' line-present flags |
| inv_ack_all_i | input | 1 | All peers acknowledged the invalidate |
| snp_cmd_i | input | 3 | Command seen on the bus |
| snp_addr_i | input | ADDR_W | Address seen on the bus |
| snp_shared_o | output | 1 | This cache holds the snooped line (read) |
| snp_supply_o | output | 1 | This cache supplies the fill word |
| snp_flush_o | output | 1 | Memory must absorb `snp_data_o` |
| snp_data_o | output | DATA_W | Word supplied or flushed |
| inv_ack_o | output | 1 | Acknowledges an invalidate seen last cycle |

## Verification
The assertions take for granted that the processor holds its request steady until `cpu_done`. They also assume only the granted cache drives the bus, that the bus lines are the OR of all caches' outputs, and that acknowledgments reach the requester only after its invalidate. The bench wires two controllers and a memory model through the arbiter to meet these conditions. It drives requests with the handshake and can hold back or inject the acknowledgment for the wait test. Its sequential sweep issues one request at a time, so the "latest write" is always well defined.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_RD   = 3'd1,
    BC_RDX  = 3'd2,
    BC_INV  = 3'd3,
    BC_WB   = 3'd4
  } bcmd_t;

  // state a held line takes after a snooped command
  function automatic mesi_t snoop_next(mesi_t cur, bcmd_t c);
    case (c)
      BC_RD:          snoop_next = (cur == ST_I) ? ST_I : ST_S;
      BC_RDX, BC_INV: snoop_next = ST_I;
      default:        snoop_next = cur;
    endcase
  endfunction

  // state a freshly filled line takes
  function automatic mesi_t fill_state(logic we, logic shared);
    if (we)          fill_state = ST_M;
    else if (shared) fill_state = ST_S;
    else             fill_state = ST_E;
  endfunction

endpackage

// File: rtl/coh_bus_arb.sv
module coh_bus_arb #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N-1:0] gnt_d;

  always_comb begin
    gnt_d = '0;
    if (|(gnt & req)) begin
      gnt_d = gnt;
    end else begin
      for (int i = N - 1; i >= 0; i--) begin
        if (req[i]) begin
          gnt_d    = '0;
          gnt_d[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gnt <= '0;
    else        gnt <= gnt_d;
  end

  assert_onehot_gnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_gnt_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & req)) |=> gnt == $past(gnt));
endmodule

// File: rtl/coh_line_store.sv
module coh_line_store
  import mesi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output mesi_t             a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_dat,
  input  logic [IDX_W-1:0]  b_idx,
  output mesi_t             b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_dat,
  input  logic              w_en,
  input  logic [IDX_W-1:0]  w_idx,
  input  mesi_t             w_st,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic [DATA_W-1:0] w_dat
);
  mesi_t             st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else if (w_en) begin
      st_q[w_idx] <= w_st;
    end
  end

  always_ff @(posedge clk) begin
    if (w_en) begin
      tag_q[w_idx] <= w_tag;
      dat_q[w_idx] <= w_dat;
    end
  end

  assign a_st  = st_q[a_idx];
  assign a_tag = tag_q[a_idx];
  assign a_dat = dat_q[a_idx];
  assign b_st  = st_q[b_idx];
  assign b_tag = tag_q[b_idx];
  assign b_dat = dat_q[b_idx];
endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              active,
  input  bcmd_t             cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  mesi_t             st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_dat,
  output logic              shared,
  output logic              supply,
  output logic              flush,
  output logic              upd,
  output mesi_t             nxt,
  output logic [DATA_W-1:0] data
);
  logic hit;
  logic owner;

  assign hit    = active && (st != ST_I) && (line_tag == snp_tag);
  assign owner  = (st == ST_E) || (st == ST_M);
  assign shared = hit && (cmd == BC_RD);
  assign supply = hit && (((cmd == BC_RD) && owner) || ((cmd == BC_RDX) && (st == ST_M)));
  assign flush  = hit && (cmd == BC_RD) && (st == ST_M);
  assign nxt    = snoop_next(st, cmd);
  assign upd    = hit && (nxt != st);
  assign data   = line_dat;
endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_fill_i,
  input  logic              bus_shared_i,
  input  logic              inv_ack_all_i,
  input  logic [2:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_supply_o,
  output logic              snp_flush_o,
  output logic [DATA_W-1:0] snp_data_o,
  output logic              inv_ack_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {F_IDLE, F_BUS, F_ACK} fsm_t;
  fsm_t fsm_q, fsm_d;

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  bcmd_t snp_cmd;
  logic  snp_active;
  assign snp_cmd    = bcmd_t'(snp_cmd_i);
  assign snp_active = (snp_cmd != BC_NONE) && !bus_gnt;

  mesi_t             a_st, b_st, s_nxt, w_st, l_st;
  logic [TAG_W-1:0]  a_tag, b_tag, w_tag, l_tag;
  logic [DATA_W-1:0] a_dat, b_dat, w_dat, l_dat;
  logic              w_en, l_we, s_upd;

  coh_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(cpu_idx), .a_st(a_st), .a_tag(a_tag), .a_dat(a_dat),
    .b_idx(snp_idx), .b_st(b_st), .b_tag(b_tag), .b_dat(b_dat),
    .w_en(w_en), .w_idx(s_upd ? snp_idx : cpu_idx),
    .w_st(w_st), .w_tag(w_tag), .w_dat(w_dat)
  );

  coh_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .active(snp_active), .cmd(snp_cmd), .snp_tag(snp_tag),
    .st(b_st), .line_tag(b_tag), .line_dat(b_dat),
    .shared(snp_shared_o), .supply(snp_supply_o), .flush(snp_flush_o),
    .upd(s_upd), .nxt(s_nxt), .data(snp_data_o)
  );

  // snooper owns the write port while the bus belongs to a peer
  assign w_en  = s_upd | l_we;
  assign w_st  = s_upd ? s_nxt : l_st;
  assign w_tag = s_upd ? b_tag : l_tag;
  assign w_dat = s_upd ? b_dat : l_dat;

  // named local events
  logic loc_hit, victim_dirty, need_inv;
  assign loc_hit      = (a_st != ST_I) && (a_tag == cpu_tag);
  assign victim_dirty = (a_st == ST_M) && (a_tag != cpu_tag);
  assign need_inv     = loc_hit && cpu_we && (a_st == ST_S);

  bcmd_t bcmd;

  always_comb begin
    fsm_d       = fsm_q;
    bcmd        = BC_NONE;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    l_we        = 1'b0;
    l_st        = ST_M;
    l_tag       = cpu_tag;
    l_dat       = cpu_wdata;
    cpu_done    = 1'b0;
    cpu_rdata   = a_dat;
    case (fsm_q)
      F_IDLE: begin
        if (cpu_valid && !snp_active) begin
          if (loc_hit && !cpu_we) begin
            cpu_done = 1'b1;
          end else if (loc_hit && cpu_we && !need_inv) begin
            l_we     = 1'b1;
            cpu_done = 1'b1;
          end else begin
            fsm_d = F_BUS;
          end
        end
      end
      F_BUS: begin
        if (bus_gnt) begin
          if (victim_dirty) begin
            bcmd        = BC_WB;
            bus_addr_o  = {a_tag, cpu_idx};
            bus_wdata_o = a_dat;
            l_we        = 1'b1;
            l_st        = ST_I;
            l_tag       = a_tag;
            l_dat       = a_dat;
          end else if (need_inv) begin
            bcmd       = BC_INV;
            bus_addr_o = cpu_addr;
            fsm_d      = F_ACK;
          end else if (loc_hit) begin
            l_we     = cpu_we;
            cpu_done = 1'b1;
            fsm_d    = F_IDLE;
          end else if (cpu_we) begin
            bcmd       = BC_RDX;
            bus_addr_o = cpu_addr;
            l_we       = 1'b1;
            cpu_done   = 1'b1;
            fsm_d      = F_IDLE;
          end else begin
            bcmd       = BC_RD;
            bus_addr_o = cpu_addr;
            l_we       = 1'b1;
            l_st       = fill_state(1'b0, bus_shared_i);
            l_dat      = bus_fill_i;
            cpu_rdata  = bus_fill_i;
            cpu_done   = 1'b1;
            fsm_d      = F_IDLE;
          end
        end
      end
      F_ACK: begin
        if (inv_ack_all_i) begin
          l_we     = 1'b1;
          cpu_done = 1'b1;
          fsm_d    = F_IDLE;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  assign bus_cmd_o = bcmd;
  assign bus_req   = (fsm_q != F_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q     <= F_IDLE;
      inv_ack_o <= 1'b0;
    end else begin
      fsm_q     <= fsm_d;
      inv_ack_o <= snp_active && (snp_cmd == BC_INV);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !bus_req && !cpu_done);
  assert_cmd_needs_gnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_o != 3'd0) |-> bus_gnt);
  assert_ack_wait_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_ACK) |-> (bus_cmd_o == 3'd0) && bus_req);
  assert_flush_supplies_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush_o |-> snp_supply_o && snp_shared_o);
  assert_done_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> cpu_valid);
  assert_one_writer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_we && s_upd));
endmodule

// File: tb/mesi_cache_ctrl_tb.sv
module mesi_cache_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       cv [2];
  logic       cwe[2];
  logic [5:0] ca [2];
  logic [7:0] cd [2];
  logic       cdone[2];
  logic [7:0] crd[2];
  logic       req[2];
  logic [1:0] gnt;
  logic [2:0] cmd[2];
  logic [5:0] badr[2];
  logic [7:0] bwd[2];
  logic       sh[2], sup[2], fl[2], ack[2];
  logic [7:0] sd[2];
  logic [7:0] fill[2];
  logic       ack_to0;
  logic       ack_block = 1'b0, ack_force = 1'b0;

  logic [2:0] bus_cmd;
  logic [5:0] bus_addr;
  logic [7:0] bus_wd;
  logic [7:0] mem   [64];
  logic [7:0] shadow[64];

  assign bus_cmd  = cmd[0] | cmd[1];
  assign bus_addr = badr[0] | badr[1];
  assign bus_wd   = bwd[0] | bwd[1];
  assign fill[0]  = sup[1] ? sd[1] : mem[bus_addr];
  assign fill[1]  = sup[0] ? sd[0] : mem[bus_addr];
  assign ack_to0  = (ack[1] & !ack_block) | ack_force;

  coh_bus_arb #(.N(2)) u_arb (.clk(clk), .rst_n(rst_n), .req({req[1], req[0]}), .gnt(gnt));

  mesi_cache_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cv[0]), .cpu_we(cwe[0]), .cpu_addr(ca[0]),
    .cpu_wdata(cd[0]), .cpu_done(cdone[0]), .cpu_rdata(crd[0]), .bus_req(req[0]),
    .bus_gnt(gnt[0]), .bus_cmd_o(cmd[0]), .bus_addr_o(badr[0]), .bus_wdata_o(bwd[0]),
    .bus_fill_i(fill[0]), .bus_shared_i(sh[1]), .inv_ack_all_i(ack_to0),
    .snp_cmd_i(bus_cmd), .snp_addr_i(bus_addr), .snp_shared_o(sh[0]),
    .snp_supply_o(sup[0]), .snp_flush_o(fl[0]), .snp_data_o(sd[0]), .inv_ack_o(ack[0]));

  mesi_cache_ctrl u_peer (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cv[1]), .cpu_we(cwe[1]), .cpu_addr(ca[1]),
    .cpu_wdata(cd[1]), .cpu_done(cdone[1]), .cpu_rdata(crd[1]), .bus_req(req[1]),
    .bus_gnt(gnt[1]), .bus_cmd_o(cmd[1]), .bus_addr_o(badr[1]), .bus_wdata_o(bwd[1]),
    .bus_fill_i(fill[1]), .bus_shared_i(sh[0]), .inv_ack_all_i(ack[0]),
    .snp_cmd_i(bus_cmd), .snp_addr_i(bus_addr), .snp_shared_o(sh[1]),
    .snp_supply_o(sup[1]), .snp_flush_o(fl[1]), .snp_data_o(sd[1]), .inv_ack_o(ack[1]));

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 7 + 3) & 8'hFF);
  endfunction

  // memory model and bus log
  int cnt[2][5];
  int supn[2], fln[2];
  int log_cmd[4096], log_iss[4096];
  int log_n = 0;
  initial for (int i = 0; i < 64; i++) mem[i] = init_val(i);

  always @(posedge clk) begin
    if (rst_n) begin
      if (bus_cmd == 3'd4) mem[bus_addr] <= bus_wd;
      if (fl[0]) mem[bus_addr] <= sd[0];
      if (fl[1]) mem[bus_addr] <= sd[1];
      if (sup[0]) supn[0]++;
      if (sup[1]) supn[1]++;
      if (fl[0]) fln[0]++;
      if (fl[1]) fln[1]++;
      if (bus_cmd != 3'd0 && bus_cmd <= 3'd4) begin
        cnt[gnt[1] ? 1 : 0][bus_cmd]++;
        if (log_n < 4096) begin
          log_cmd[log_n] = int'(bus_cmd);
          log_iss[log_n] = gnt[1] ? 1 : 0;
          log_n++;
        end
      end
    end
  end

  int checks = 0, errors = 0;
  int snap[2][5];
  int snap_sup[2], snap_fl[2], snap_log;

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic take_snap();
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 5; k++) snap[c][k] = cnt[c][k];
      snap_sup[c] = supn[c];
      snap_fl[c]  = fln[c];
    end
    snap_log = log_n;
  endtask

  function automatic int dcmd(int c, int k);
    return cnt[c][k] - snap[c][k];
  endfunction

  function automatic int dall();
    int s = 0;
    for (int c = 0; c < 2; c++) for (int k = 1; k < 5; k++) s += dcmd(c, k);
    return s;
  endfunction

  task automatic op(input int c, input bit we, input logic [5:0] a, input logic [7:0] d,
                    output logic [7:0] r);
    @(negedge clk);
    cv[c] = 1'b1; cwe[c] = we; ca[c] = a; cd[c] = d;
    forever begin
      @(negedge clk);
      if (cdone[c]) break;
    end
    r = crd[c];
    @(posedge clk);
    #1;
    cv[c] = 1'b0;
    if (we) shadow[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [5:0] A  = 6'h05, B = 6'h0A, C = 6'h0F;
  localparam logic [5:0] D  = 6'h10, D2 = 6'h20, D3 = 6'h30;

  initial begin
    logic [7:0] r, r1;
    logic [15:0] lf;
    bit saw;
    for (int i = 0; i < 64; i++) shadow[i] = init_val(i);
    for (int c = 0; c < 2; c++) begin
      cv[c] = 0; cwe[c] = 0; ca[c] = '0; cd[c] = '0;
      supn[c] = 0; fln[c] = 0;
      for (int k = 0; k < 5; k++) cnt[c][k] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!req[0] && !req[1], "R1 bus_req", int'(req[0]), 0);
    chk(!cdone[0] && bus_cmd == 0, "R1 done/cmd", int'(bus_cmd), 0);

    // R2 read miss from memory, installs Exclusive
    take_snap();
    op(0, 0, A, 0, r);
    chk(r == shadow[A], "R2 data", r, shadow[A]);
    chk(dcmd(0, 1) == 1, "R2 read issued", dcmd(0, 1), 1);
    // R7 write hit Exclusive then Modified: silent
    take_snap();
    op(0, 1, A, 8'h5A, r);
    op(0, 1, A, 8'h5B, r);
    chk(dall() == 0, "R7 silent upgrade", dall(), 0);

    // R5 peer read of a Modified line: flush and supply
    take_snap();
    op(1, 0, A, 0, r);
    chk(r == 8'h5B, "R5 data", r, 8'h5B);
    chk(mem[A] == 8'h5B, "R5 memory flushed", mem[A], 8'h5B);
    chk(fln[0] - snap_fl[0] == 1, "R5 flush", fln[0] - snap_fl[0], 1);

    // R6 write to Shared line invalidates the peer
    take_snap();
    op(1, 1, A, 8'h66, r);
    chk(dcmd(1, 3) == 1, "R6 invalidate", dcmd(1, 3), 1);
    take_snap();
    op(0, 0, A, 0, r);
    chk(dcmd(0, 1) == 1 && r == 8'h66, "R6 peer invalidated", r, 8'h66);

    // R6 completion waits for the acknowledgment
    ack_block = 1'b1;
    saw = 0;
    fork
      op(0, 1, A, 8'h77, r);
      begin
        repeat (12) begin
          @(negedge clk);
          if (cdone[0]) saw = 1;
        end
        chk(!saw, "R6 waits for ack", int'(saw), 0);
        ack_force = 1'b1;
        @(negedge clk);
        ack_force = 1'b0;
      end
    join
    ack_block = 1'b0;
    op(1, 0, A, 0, r);
    chk(r == 8'h77, "R6 written after ack", r, 8'h77);

    // R4 peer read of an Exclusive line: cache-to-cache, no memory write
    op(0, 0, B, 0, r);
    take_snap();
    op(1, 0, B, 0, r);
    chk(r == shadow[B], "R4 data", r, shadow[B]);
    chk(supn[0] - snap_sup[0] == 1, "R4 supplied", supn[0] - snap_sup[0], 1);
    chk(fln[0] - snap_fl[0] == 0, "R4 no flush", fln[0] - snap_fl[0], 0);
    take_snap();
    op(0, 1, B, 8'h44, r);
    chk(dcmd(0, 3) == 1, "R4 supplier now Shared", dcmd(0, 3), 1);

    // R8 write miss: read-for-ownership
    take_snap();
    op(0, 1, C, 8'h11, r);
    chk(dcmd(0, 2) == 1, "R8 rdx issued", dcmd(0, 2), 1);
    take_snap();
    op(1, 1, C, 8'h22, r);
    chk(dcmd(1, 2) == 1, "R8 peer rdx", dcmd(1, 2), 1);
    chk(supn[0] - snap_sup[0] == 1, "R8 dirty supplied", supn[0] - snap_sup[0], 1);
    chk(mem[C] == init_val(int'(C)), "R8 no memory write", mem[C], init_val(int'(C)));
    op(0, 0, C, 0, r);
    chk(r == 8'h22, "R8 old owner invalid", r, 8'h22);

    // R9 dirty eviction writes back before the fill
    op(0, 1, D, 8'h33, r);
    take_snap();
    op(0, 0, D2, 0, r);
    chk(log_n - snap_log == 2 && log_cmd[snap_log] == 4 && log_cmd[snap_log + 1] == 1,
        "R9 wb then read", log_cmd[snap_log], 4);
    chk(mem[D] == 8'h33, "R9 memory updated", mem[D], 8'h33);
    chk(r == shadow[D2], "R9 fill data", r, shadow[D2]);
    take_snap();
    op(0, 0, D3, 0, r);
    chk(dcmd(0, 4) == 0, "R9 clean eviction silent", dcmd(0, 4), 0);

    // R3 read hit
    take_snap();
    op(0, 0, D3, 0, r);
    chk(dall() == 0 && r == shadow[D3], "R3 hit", dall(), 0);

    // R10 simultaneous misses: lower index first
    take_snap();
    fork
      op(0, 0, 6'h09, 0, r);
      op(1, 0, 6'h0E, 0, r1);
    join
    chk(log_iss[snap_log] == 0, "R10 priority", log_iss[snap_log], 0);
    chk(r == shadow[6'h09] && r1 == shadow[6'h0E], "R10 both served", r1, shadow[6'h0E]);

    // R11 sequential sweep over conflicting addresses
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      int c;
      bit w;
      logic [5:0] a;
      lf = {lf[14:0], 1'b0} ^ (lf[15] ? 16'h100B : 16'h0000);
      c = int'(lf[0]);
      w = lf[3];
      a = {2'b00, lf[9:6]};
      op(c, w, a, lf[15:8], r);
      if (!w) chk(r == shadow[a], "R11 sweep read", r, shadow[a]);
    end
    for (int a = 0; a < 16; a++) begin
      for (int c = 0; c < 2; c++) begin
        op(c, 0, 6'(a), 0, r);
        chk(r == shadow[a], "R11 final read", r, shadow[a]);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule